// File: doc/BRIEF.md
# Raster Scan Trigger Pulse Generator

This block produces three synchronization strobes for a raster-scanning system: a per-sample pixel strobe, a line strobe and a frame strobe. A sample-period counter paces the scan in whole clock cycles. A sample index walks each line through its lead-in, imaging, flyback and settle samples, and a line counter walks the lines of a frame. A strobe is produced only for samples that fall inside a programmable imaging window. The line and frame strobes are never independent clocks. They ride on the first pixel strobe of a line or of a frame and share its edges.

The block is started and stopped with one enable input. While it is enabled it scans frame after frame without a gap. It captures its configuration when a frame begins, so software may change the settings at any moment and the new values apply cleanly from the next frame. Two pulse-width modes are available. In the short mode every strobe lasts a few clocks. In the hold mode the line-start strobes are stretched to a programmed length. No width can reach the next sample.

Top module: `raster_trig`

## Requirements
- R1: Samples occur every cfg_period clocks, with cfg_period below 2 treated as 2. Pixel rising edges within one line are spaced exactly cfg_period clocks apart. After enable is first seen high at clock edge E0, the first pixel strobe rises after edge E0 + 1 + cfg_img_start*cfg_period.
- R2: The pixel strobe fires only for sample indices i with cfg_img_start <= i < cfg_img_end. A frame therefore carries cfg_lines*(cfg_img_end-cfg_img_start) pixel strobes, or none if cfg_img_end <= cfg_img_start.
- R3: trig_frame fires only on the first imaging sample (i == cfg_img_start) of line 0, and it fires together with trig_line and trig_pixel.
- R4: trig_line fires together with trig_pixel on the first imaging sample of every line. It never fires without trig_pixel. On lines other than line 0, trig_frame stays low.
- R5: All strobes that fire on the same sample rise in the same cycle and fall in the same cycle.
- R6: With cfg_long = 0, every strobe is high for MIN_PW (default 3) clocks. With cfg_long = 1, line-start strobes are high for cfg_width clocks (0 is treated as 1), and all other pixel strobes stay at MIN_PW.
- R7: A requested width greater than or equal to the sample period is reduced to period-1 clocks, so successive strobes stay separate.
- R8: The sample index wraps to 0 after cfg_samples-1 and advances the line. The line wraps after cfg_lines-1. Each of the back-to-back frames that follow begins with a frame strobe.
- R9: While enable is low, all three strobes and busy are low from the next clock edge. A later enable restarts the scan at sample 0 of line 0.
- R10: The configuration is captured at frame start. A change made during a frame applies only from the next frame.
- R11: busy goes high on the edge after enable is seen high and stays high while the scan runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run the scan while high |
| cfg_period | input | CNT_W | Clocks per sample |
| cfg_img_start | input | IDX_W | First imaging sample index |
| cfg_img_end | input | IDX_W | Imaging window end index (exclusive) |
| cfg_samples | input | IDX_W | Samples per line |
| cfg_lines | input | LIN_W | Lines per frame |
| cfg_long | input | 1 | 1 = line-start strobes use cfg_width |
| cfg_width | input | CNT_W | Hold length in clocks for line-start strobes |
| trig_frame | output | 1 | Frame strobe |
| trig_line | output | 1 | Line strobe |
| trig_pixel | output | 1 | Pixel strobe |
| busy | output | 1 | Scan running |

## Verification
Several events fall on the final clock of a frame in the same cycle: the period counter reaches its terminal count, the sample index and the line wrap, and the configuration is captured again. One cycle later comes the first tick of the new frame. The bench provokes this by changing the window end in the middle of a frame and then running two frames back to back. It judges the result by the exact pixel count, which must come from the old setting in the first frame and the new setting in the second, and by one frame strobe for each frame. A clamped strobe also falls one clock short of the next sample tick, and the short-period vectors check that a falling edge is still seen between strobes.

// File: rtl/raster_trig.sv
module raster_trig #(
  parameter int CNT_W  = 16,
  parameter int IDX_W  = 12,
  parameter int LIN_W  = 12,
  parameter int MIN_PW = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [CNT_W-1:0] cfg_period,
  input  logic [IDX_W-1:0] cfg_img_start,
  input  logic [IDX_W-1:0] cfg_img_end,
  input  logic [IDX_W-1:0] cfg_samples,
  input  logic [LIN_W-1:0] cfg_lines,
  input  logic             cfg_long,
  input  logic [CNT_W-1:0] cfg_width,
  output logic             trig_frame,
  output logic             trig_line,
  output logic             trig_pixel,
  output logic             busy
);
  localparam logic [CNT_W-1:0] MINW = CNT_W'(MIN_PW);

  logic             running;
  logic [CNT_W-1:0] per_q, wid_q, cnt, left;
  logic [IDX_W-1:0] st_q, end_q, spl_q, idx;
  logic [LIN_W-1:0] lpf_q, lin;
  logic             long_q;

  wire per_last   = cnt == per_q - 1'b1;
  wire line_last  = idx == spl_q - 1'b1;
  wire frame_last = lin == lpf_q - 1'b1;
  wire frame_end  = running && per_last && line_last && frame_last;
  wire tick       = running && cnt == '0;
  wire in_win     = idx >= st_q && idx < end_q;
  wire first      = idx == st_q;

  wire [CNT_W-1:0] want  = (long_q && first) ? wid_q : MINW;
  wire [CNT_W-1:0] want1 = (want == '0) ? CNT_W'(1) : want;
  wire [CNT_W-1:0] eff   = (want1 >= per_q) ? per_q - 1'b1 : want1;

  assign busy = running;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      cnt <= '0; idx <= '0; lin <= '0; left <= '0;
      per_q <= CNT_W'(2); wid_q <= '0; long_q <= 1'b0;
      st_q <= '0; end_q <= '0; spl_q <= IDX_W'(1); lpf_q <= LIN_W'(1);
      trig_frame <= 1'b0; trig_line <= 1'b0; trig_pixel <= 1'b0;
    end else if (!enable) begin
      running <= 1'b0;
      cnt <= '0; idx <= '0; lin <= '0; left <= '0;
      trig_frame <= 1'b0; trig_line <= 1'b0; trig_pixel <= 1'b0;
    end else begin
      if (!running || frame_end) begin
        per_q  <= (cfg_period < CNT_W'(2)) ? CNT_W'(2) : cfg_period;
        st_q   <= cfg_img_start;
        end_q  <= cfg_img_end;
        spl_q  <= (cfg_samples == '0) ? IDX_W'(1) : cfg_samples;
        lpf_q  <= (cfg_lines == '0) ? LIN_W'(1) : cfg_lines;
        long_q <= cfg_long;
        wid_q  <= cfg_width;
      end
      if (!running) begin
        running <= 1'b1;
        cnt <= '0; idx <= '0; lin <= '0;
      end else begin
        cnt <= per_last ? '0 : cnt + 1'b1;
        if (per_last) begin
          idx <= line_last ? '0 : idx + 1'b1;
          if (line_last) lin <= frame_last ? '0 : lin + 1'b1;
        end
      end
      if (tick && in_win) begin
        trig_pixel <= 1'b1;
        trig_line  <= first;
        trig_frame <= first && lin == '0;
        left       <= eff - 1'b1;
      end else if (left != '0) begin
        left <= left - 1'b1;
      end else begin
        trig_frame <= 1'b0; trig_line <= 1'b0; trig_pixel <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/raster_trig_chk.sv
module raster_trig_chk (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic trig_frame,
  input logic trig_line,
  input logic trig_pixel,
  input logic busy
);
  p_frame_has_line_r3: assert property (@(posedge clk) disable iff (!rst_n)
    trig_frame |-> trig_line);
  p_line_has_pixel_r4: assert property (@(posedge clk) disable iff (!rst_n)
    trig_line |-> trig_pixel);
  p_common_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trig_line) |-> $rose(trig_pixel));
  p_common_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(trig_line) |-> $fell(trig_pixel));
  p_frame_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trig_frame) |-> $rose(trig_line));
  p_quiet_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!trig_pixel && !trig_line && !trig_frame && !busy));
endmodule

bind raster_trig raster_trig_chk u_chk (.*);

// File: tb/tb_raster_trig.sv
`timescale 1ns/1ps
module tb_raster_trig;
  logic clk = 0, rst_n = 0, enable = 0;
  logic [15:0] cfg_period = 8, cfg_width = 0;
  logic [11:0] cfg_img_start = 0, cfg_img_end = 0, cfg_samples = 1, cfg_lines = 1;
  logic cfg_long = 0;
  logic trig_frame, trig_line, trig_pixel, busy;

  raster_trig dut (.*);

  always #10 clk = ~clk;

  int checks = 0, fails = 0;
  int n_pix, n_line, n_frame, werr, aerr, perr;
  int exp_pw, exp_lw, cur_per;
  int cyc = 0, run = 0, last_rise = -1;
  logic had_line = 0, pp = 0, pl = 0, pf = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (trig_line && !trig_pixel) aerr++;
    if (trig_frame && !trig_line) aerr++;
    if (trig_line && !pl && pp) aerr++;
    if (pl && pp && trig_pixel && !trig_line) aerr++;
    if (trig_pixel && !pp) begin
      n_pix++;
      if (trig_line) begin n_line++; last_rise = cyc; end
      else begin
        if (last_rise >= 0 && cyc - last_rise != cur_per) perr++;
        last_rise = cyc;
      end
      if (trig_frame) n_frame++;
      run = 1; had_line = trig_line;
    end else if (trig_pixel) run++;
    if (!trig_pixel && pp) begin
      if (run != (had_line ? exp_lw : exp_pw)) werr++;
    end
    pp = trig_pixel; pl = trig_line; pf = trig_frame;
  end

  task automatic clear_stats();
    n_pix = 0; n_line = 0; n_frame = 0; werr = 0; aerr = 0; perr = 0; last_rise = -1;
  endtask

  task automatic set_cfg(input int p, st, en, spl, lpf, lng, w);
    cfg_period = 16'(p); cfg_img_start = 12'(st); cfg_img_end = 12'(en);
    cfg_samples = 12'(spl); cfg_lines = 12'(lpf); cfg_long = lng[0]; cfg_width = 16'(w);
  endtask

  task automatic run_frames(input int cycles);
    @(negedge clk);
    clear_stats();
    enable = 1;
    repeat (cycles + 1) @(posedge clk);
    @(negedge clk);
    enable = 0;
    @(posedge clk); @(negedge clk);
    check(!trig_pixel && !trig_line && !trig_frame && !busy, "R9 outputs low after disable",
          {trig_frame, trig_line, trig_pixel, busy}, 0);
  endtask

  localparam int NV = 6;
  localparam int V[NV][12] = '{
    '{8, 2, 7, 10, 3, 0, 0,  15, 3, 1, 3, 3},
    '{8, 2, 7, 10, 3, 1, 5,  15, 3, 1, 3, 5},
    '{8, 1, 4, 6,  2, 1, 20, 6,  2, 1, 3, 7},
    '{4, 0, 5, 5,  2, 1, 0,  10, 2, 1, 3, 1},
    '{6, 4, 4, 8,  2, 0, 0,  0,  0, 0, 3, 3},
    '{2, 3, 9, 9,  2, 0, 0,  12, 2, 1, 1, 1}
  };

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int k;
    clear_stats();
    repeat (3) @(negedge clk);
    check(!trig_pixel && !trig_line && !trig_frame && !busy, "R9 reset state", {trig_frame, trig_line, trig_pixel, busy}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    check(!busy && !trig_pixel, "R11 idle before enable", busy, 0);

    for (int v = 0; v < NV; v++) begin
      set_cfg(V[v][0], V[v][1], V[v][2], V[v][3], V[v][4], V[v][5], V[v][6]);
      cur_per = V[v][0]; exp_pw = V[v][10]; exp_lw = V[v][11];
      run_frames(V[v][0] * V[v][3] * V[v][4]);
      check(n_pix == V[v][7], $sformatf("R2 pixel count vec%0d", v), n_pix, V[v][7]);
      check(n_line == V[v][8], $sformatf("R4 line count vec%0d", v), n_line, V[v][8]);
      check(n_frame == V[v][9], $sformatf("R3 frame count vec%0d", v), n_frame, V[v][9]);
      check(werr == 0, $sformatf("R6 R7 pulse widths vec%0d", v), werr, 0);
      check(aerr == 0, $sformatf("R5 edge alignment vec%0d", v), aerr, 0);
      check(perr == 0, $sformatf("R1 pixel spacing vec%0d", v), perr, 0);
    end

    set_cfg(8, 2, 7, 10, 3, 0, 0);
    cur_per = 8; exp_pw = 3; exp_lw = 3;
    run_frames(2 * 240);
    check(n_frame == 2, "R8 frame strobe each frame", n_frame, 2);
    check(n_line == 6, "R8 line wrap", n_line, 6);
    check(n_pix == 30, "R8 pixels over two frames", n_pix, 30);

    @(negedge clk);
    clear_stats();
    enable = 1;
    repeat (21) @(posedge clk);
    @(negedge clk);
    cfg_img_end = 9;
    repeat (2 * 240 - 20) @(posedge clk);
    @(negedge clk);
    enable = 0;
    @(posedge clk); @(negedge clk);
    check(n_pix == 36, "R10 mid-frame change applies next frame", n_pix, 36);
    check(n_frame == 2, "R10 frame strobes", n_frame, 2);

    cfg_img_end = 7;
    @(negedge clk);
    enable = 1;
    repeat (100) @(posedge clk);
    @(negedge clk);
    enable = 0;
    @(posedge clk); @(negedge clk);
    check(!trig_pixel && !trig_line && !trig_frame && !busy, "R9 mid-frame disable",
          {trig_frame, trig_line, trig_pixel, busy}, 0);

    @(negedge clk);
    enable = 1;
    @(posedge clk);
    @(negedge clk);
    check(busy == 1, "R11 busy after enable", busy, 1);
    k = 1;
    while (!trig_pixel && k < 1000) begin
      @(posedge clk); @(negedge clk);
      if (!trig_pixel) k++;
    end
    check(k == 17, "R1 first pixel timing", k, 17);
    check(trig_frame && trig_line, "R9 restart begins with frame strobe", {trig_frame, trig_line}, 3);
    @(negedge clk);
    enable = 0;
    repeat (3) @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule